// File: doc/BRIEF.md
# Paired-Access Packet Register File

This block is the general register file behind an execution core that issues one packet of up to four operation slots every clock. It stores 32 registers of 32 bits. Every slot owns two read ports and one write port. Each port works on either a single 32-bit register or an aligned register pair treated as one 64-bit value. In a pair, the register at the even index holds bits 31:0 and the next odd register holds bits 63:32.

All writes of a packet commit together on a single clock edge. All reads of that packet return the contents from before the packet. When two slots of one packet write the same 32-bit register, the whole packet's writes are dropped and an error flag is raised. A pair request that starts on an odd index is flagged and ignored.

Read data and all flags are registered and appear one clock after the packet is presented. Read port `2*s` and read port `2*s+1` belong to slot `s`.

Top module: `vrf_pair_regfile`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every register reads as zero and `rd_data`, `rd_misalign`, `wr_misalign` and `conflict_err` are all zero.
- R2: A single-register write (`wr_pair`=0) stores `wr_data[31:0]` at the clock edge of its packet. A single read (`rd_pair`=0) returns the register in bits 31:0 of `rd_data` one clock after the request, with bits 63:32 at zero.
- R3: A pair write at even index k stores `wr_data[31:0]` in register k and `wr_data[63:32]` in register k+1. A pair read at even k returns {register k+1, register k} one clock after the request.
- R4: Every read of a packet returns the values from before that packet, including reads of registers the same packet writes.
- R5: Writes from up to four slots to disjoint registers all become visible together, starting with the next packet.
- R6: If the registers touched by two valid, aligned writes of one packet overlap (single/single, single/pair or pair/pair), `conflict_err` is high in the following cycle and no write of that packet is committed.
- R7: A read with `rd_pair`=1 and an odd `rd_idx` sets that port's `rd_misalign` bit in the following cycle and returns zero data.
- R8: A write with `wr_pair`=1 and an odd `wr_idx` sets that slot's `wr_misalign` bit in the following cycle. That write is dropped and takes no part in conflict detection, while the other slots' writes still commit.
- R9: A read port whose `rd_en` is low returns zero data and a clear `rd_misalign` bit in the following cycle.
- R10: A packet whose writes are dropped for a conflict still delivers its reads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 8 | Read request per port (port 2s and 2s+1 belong to slot s) |
| rd_pair | input | 8 | Read port asks for a 64-bit pair |
| rd_idx | input | 8x5 | Register index per read port |
| wr_en | input | 4 | Write request per slot |
| wr_pair | input | 4 | Write is a 64-bit pair |
| wr_idx | input | 4x5 | Register index per write slot |
| wr_data | input | 4x64 | Write data; single writes use bits 31:0 |
| rd_data | output | 8x64 | Registered read data per port |
| rd_misalign | output | 8 | Registered odd-pair read flag per port |
| wr_misalign | output | 4 | Registered odd-pair write flag per slot |
| conflict_err | output | 1 | Registered intra-packet write overlap flag |

## Verification
The hardest case to reach is an overlap between a pair write and a single write in one packet. Such a packet has to be dropped completely, and the proof of the drop only shows later, through reads of both halves of the pair. The random packets therefore draw their write indices from a narrow window of eight registers, so single/pair and pair/pair overlaps happen often. Odd pair indices are mixed into the same packets so that dropped writes sit next to conflicts. A closing sweep reads every register to confirm the stored contents match the model.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  parameter int DEF_NUM_REGS  = 32;
  parameter int DEF_XLEN      = 32;
  parameter int DEF_NUM_SLOTS = 4;
  parameter int RD_PER_SLOT   = 2;

  typedef enum logic {
    ACC_SINGLE = 1'b0,
    ACC_PAIR   = 1'b1
  } acc_width_e;
endpackage

// File: rtl/vrf_wr_ctrl.sv
module vrf_wr_ctrl #(
  parameter int NUM_REGS  = 32,
  parameter int XLEN      = 32,
  parameter int NUM_SLOTS = 4,
  parameter int IDXW      = $clog2(NUM_REGS)
) (
  input  logic [NUM_SLOTS-1:0]                wr_en,
  input  logic [NUM_SLOTS-1:0]                wr_pair,
  input  logic [NUM_SLOTS-1:0][IDXW-1:0]      wr_idx,
  input  logic [NUM_SLOTS-1:0][2*XLEN-1:0]    wr_data,
  output logic [NUM_REGS-1:0]                 reg_we,
  output logic [NUM_REGS-1:0][XLEN-1:0]       reg_wd,
  output logic                                conflict,
  output logic [NUM_SLOTS-1:0]                misalign
);
  import vrf_pkg::*;

  localparam logic [NUM_REGS-1:0] ONE_HOT  = NUM_REGS'(1);
  localparam logic [NUM_REGS-1:0] TWO_HOT  = NUM_REGS'(3);

  logic [NUM_SLOTS-1:0][NUM_REGS-1:0] touch;
  logic [NUM_REGS-1:0]                any_we;

  // per-slot footprint of registers touched
  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      misalign[s] = wr_en[s] && (acc_width_e'(wr_pair[s]) == ACC_PAIR) && wr_idx[s][0];
      if (wr_en[s] && !misalign[s])
        touch[s] = (wr_pair[s] ? TWO_HOT : ONE_HOT) << wr_idx[s];
      else
        touch[s] = '0;
    end
  end

  // pairwise overlap test between slots
  always_comb begin
    conflict = 1'b0;
    for (int a = 0; a < NUM_SLOTS; a++)
      for (int b = a + 1; b < NUM_SLOTS; b++)
        if (|(touch[a] & touch[b]))
          conflict = 1'b1;
  end

  // steer data halves to each register
  always_comb begin
    any_we = '0;
    reg_wd = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (touch[s][r]) begin
          any_we[r] = 1'b1;
          if (wr_pair[s] && (r % 2 == 1))
            reg_wd[r] = wr_data[s][2*XLEN-1:XLEN];
          else
            reg_wd[r] = wr_data[s][XLEN-1:0];
        end
      end
    end
  end

  assign reg_we = conflict ? '0 : any_we;
endmodule

// File: rtl/vrf_rd_port.sv
module vrf_rd_port #(
  parameter int NUM_REGS = 32,
  parameter int XLEN     = 32,
  parameter int IDXW     = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic                          pair,
  input  logic [IDXW-1:0]               idx,
  input  logic [NUM_REGS-1:0][XLEN-1:0] regs,
  output logic [2*XLEN-1:0]             data_q,
  output logic                          mis_q
);
  logic [IDXW-1:0]   hi_idx;
  logic              bad;
  logic [2*XLEN-1:0] data_d;

  assign hi_idx = idx | IDXW'(1);
  assign bad    = en && pair && idx[0];

  always_comb begin
    if (!en || bad)
      data_d = '0;
    else if (pair)
      data_d = {regs[hi_idx], regs[idx]};
    else
      data_d = {{XLEN{1'b0}}, regs[idx]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      mis_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      mis_q  <= bad;
    end
  end
endmodule

// File: rtl/vrf_pair_regfile.sv
module vrf_pair_regfile #(
  parameter int NUM_REGS  = vrf_pkg::DEF_NUM_REGS,
  parameter int XLEN      = vrf_pkg::DEF_XLEN,
  parameter int NUM_SLOTS = vrf_pkg::DEF_NUM_SLOTS,
  localparam int IDXW     = $clog2(NUM_REGS),
  localparam int NRD      = NUM_SLOTS * vrf_pkg::RD_PER_SLOT
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NRD-1:0]                   rd_en,
  input  logic [NRD-1:0]                   rd_pair,
  input  logic [NRD-1:0][IDXW-1:0]         rd_idx,
  input  logic [NUM_SLOTS-1:0]             wr_en,
  input  logic [NUM_SLOTS-1:0]             wr_pair,
  input  logic [NUM_SLOTS-1:0][IDXW-1:0]   wr_idx,
  input  logic [NUM_SLOTS-1:0][2*XLEN-1:0] wr_data,
  output logic [NRD-1:0][2*XLEN-1:0]       rd_data,
  output logic [NRD-1:0]                   rd_misalign,
  output logic [NUM_SLOTS-1:0]             wr_misalign,
  output logic                             conflict_err
);
  logic [NUM_REGS-1:0][XLEN-1:0] regs;
  logic [NUM_REGS-1:0]           reg_we;
  logic [NUM_REGS-1:0][XLEN-1:0] reg_wd;
  logic                          conflict_d;
  logic [NUM_SLOTS-1:0]          wmis_d;

  vrf_wr_ctrl #(
    .NUM_REGS(NUM_REGS), .XLEN(XLEN), .NUM_SLOTS(NUM_SLOTS), .IDXW(IDXW)
  ) u_wr_ctrl (
    .wr_en(wr_en), .wr_pair(wr_pair), .wr_idx(wr_idx), .wr_data(wr_data),
    .reg_we(reg_we), .reg_wd(reg_wd), .conflict(conflict_d), .misalign(wmis_d)
  );

  // storage: one enable per register, all commit on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++)
        if (reg_we[r])
          regs[r] <= reg_wd[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conflict_err <= 1'b0;
      wr_misalign  <= '0;
    end else begin
      conflict_err <= conflict_d;
      wr_misalign  <= wmis_d;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    vrf_rd_port #(
      .NUM_REGS(NUM_REGS), .XLEN(XLEN), .IDXW(IDXW)
    ) u_rd (
      .clk(clk), .rst(rst), .en(rd_en[p]), .pair(rd_pair[p]), .idx(rd_idx[p]),
      .regs(regs), .data_q(rd_data[p]), .mis_q(rd_misalign[p])
    );
  end
endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
  parameter int NUM_REGS  = 32,
  parameter int XLEN      = 32,
  parameter int NUM_SLOTS = 4,
  parameter int IDXW      = 5,
  parameter int NRD       = 8
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NRD-1:0]                   rd_en,
  input logic [NRD-1:0]                   rd_pair,
  input logic [NRD-1:0][IDXW-1:0]         rd_idx,
  input logic [NUM_SLOTS-1:0]             wr_en,
  input logic [NUM_SLOTS-1:0]             wr_pair,
  input logic [NUM_SLOTS-1:0][IDXW-1:0]   wr_idx,
  input logic [NRD-1:0][2*XLEN-1:0]       rd_data,
  input logic [NRD-1:0]                   rd_misalign,
  input logic [NUM_SLOTS-1:0]             wr_misalign,
  input logic                             conflict_err,
  input logic [NUM_REGS-1:0][XLEN-1:0]    regs
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (conflict_err == 1'b0 && wr_misalign == '0 && rd_misalign == '0));

  p_conflict_holds_state_r6: assert property (@(posedge clk) disable iff (rst)
    conflict_err |-> regs == $past(regs));

  p_same_single_conflict_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en[0] && wr_en[1] && !wr_pair[0] && !wr_pair[1] && wr_idx[0] == wr_idx[1])
      |=> conflict_err);

  for (genvar p = 0; p < NRD; p++) begin : g_rd_chk
    p_odd_pair_read_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_en[p] && rd_pair[p] && rd_idx[p][0]) |=> (rd_misalign[p] && rd_data[p] == '0));

    p_idle_port_zero_r9: assert property (@(posedge clk) disable iff (rst)
      !rd_en[p] |=> (rd_data[p] == '0 && !rd_misalign[p]));

    p_single_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_en[p] && !rd_pair[p]) |=> rd_data[p][2*XLEN-1:XLEN] == '0);
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_wr_chk
    p_odd_pair_write_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en[s] && wr_pair[s] && wr_idx[s][0]) |=> wr_misalign[s]);
  end
endmodule

bind vrf_pair_regfile vrf_checker #(
  .NUM_REGS(NUM_REGS), .XLEN(XLEN), .NUM_SLOTS(NUM_SLOTS), .IDXW(IDXW), .NRD(NRD)
) u_vrf_checker (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_pair(rd_pair), .rd_idx(rd_idx),
  .wr_en(wr_en), .wr_pair(wr_pair), .wr_idx(wr_idx), .rd_data(rd_data),
  .rd_misalign(rd_misalign), .wr_misalign(wr_misalign),
  .conflict_err(conflict_err), .regs(regs)
);

// File: tb/vrf_pair_regfile_bench.sv
`timescale 1ns/1ps
module vrf_pair_regfile_bench;
  localparam int NR = 32;
  localparam int NS = 4;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NP-1:0]        rd_en = '0, rd_pair = '0;
  logic [NP-1:0][4:0]   rd_idx = '0;
  logic [NS-1:0]        wr_en = '0, wr_pair = '0;
  logic [NS-1:0][4:0]   wr_idx = '0;
  logic [NS-1:0][63:0]  wr_data = '0;
  logic [NP-1:0][63:0]  rd_data;
  logic [NP-1:0]        rd_misalign;
  logic [NS-1:0]        wr_misalign;
  logic                 conflict_err;

  vrf_pair_regfile u_vrf_pair_regfile (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_pair(rd_pair), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_pair(wr_pair), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_data(rd_data), .rd_misalign(rd_misalign), .wr_misalign(wr_misalign),
    .conflict_err(conflict_err)
  );

  logic [31:0] model [NR];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_pkt();
    rd_en = '0; rd_pair = '0; rd_idx = '0;
    wr_en = '0; wr_pair = '0; wr_idx = '0; wr_data = '0;
  endtask

  task automatic set_rd(input int p, input bit pr, input int idx);
    rd_en[p] = 1'b1; rd_pair[p] = pr; rd_idx[p] = 5'(idx);
  endtask

  task automatic set_wr(input int s, input bit pr, input int idx, input logic [63:0] d);
    wr_en[s] = 1'b1; wr_pair[s] = pr; wr_idx[s] = 5'(idx); wr_data[s] = d;
  endtask

  // one packet: predict, clock, compare, then update model
  task automatic packet(input string tag);
    logic [63:0] exp_d [NP];
    bit          exp_m [NP];
    bit          exp_w [NS];
    int          cnt [NR];
    bit          conf;
    string       t;
    for (int p = 0; p < NP; p++) begin
      exp_m[p] = 0; exp_d[p] = '0;
      if (rd_en[p]) begin
        if (rd_pair[p] && rd_idx[p][0]) exp_m[p] = 1;
        else if (rd_pair[p]) exp_d[p] = {model[int'(rd_idx[p]) + 1], model[int'(rd_idx[p])]};
        else exp_d[p] = {32'h0, model[int'(rd_idx[p])]};
      end
    end
    for (int r = 0; r < NR; r++) cnt[r] = 0;
    for (int s = 0; s < NS; s++) begin
      exp_w[s] = wr_en[s] && wr_pair[s] && wr_idx[s][0];
      if (wr_en[s] && !exp_w[s]) begin
        cnt[int'(wr_idx[s])]++;
        if (wr_pair[s]) cnt[int'(wr_idx[s]) + 1]++;
      end
    end
    conf = 0;
    for (int r = 0; r < NR; r++) if (cnt[r] > 1) conf = 1;
    @(posedge clk); #1;
    for (int p = 0; p < NP; p++) begin
      if (tag != "") t = tag;
      else if (!rd_en[p]) t = "R9";
      else if (exp_m[p]) t = "R7";
      else if (rd_pair[p]) t = "R3";
      else t = "R2";
      chk(t, {63'h0, rd_misalign[p], rd_data[p]}, {63'h0, exp_m[p], exp_d[p]});
    end
    for (int s = 0; s < NS; s++) chk("R8", 128'(wr_misalign[s]), 128'(exp_w[s]));
    chk("R6", 128'(conflict_err), 128'(conf));
    if (!conf)
      for (int s = 0; s < NS; s++)
        if (wr_en[s] && !exp_w[s]) begin
          model[int'(wr_idx[s])] = wr_data[s][31:0];
          if (wr_pair[s]) model[int'(wr_idx[s]) + 1] = wr_data[s][63:32];
        end
  endtask

  task automatic sweep(input string tag);
    for (int b = 0; b < NR; b += 16) begin
      clear_pkt();
      for (int p = 0; p < NP; p++) set_rd(p, 1, b + 2 * p);
      packet(tag);
    end
  endtask

  initial begin
    for (int r = 0; r < NR; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet under reset
    for (int p = 0; p < NP; p++) chk("R1", {63'h0, rd_misalign[p], rd_data[p]}, '0);
    chk("R1", {123'h0, wr_misalign, conflict_err}, '0);
    rst = 1'b0;
    sweep("R1");

    // R2: single write then read
    clear_pkt(); set_wr(0, 0, 5, 64'hdead_0000_1234_5678); packet("R2");
    clear_pkt(); set_rd(0, 0, 5); set_rd(1, 0, 6); packet("R2");

    // R3: pair write at 16, read pair and halves
    clear_pkt(); set_wr(1, 1, 16, 64'haaaa_bbbb_cccc_dddd); packet("R3");
    clear_pkt(); set_rd(2, 1, 16); set_rd(3, 0, 17); set_rd(4, 0, 16); packet("R3");

    // R4: read returns pre-packet value of a register written in the same packet
    clear_pkt(); set_wr(2, 0, 5, 64'h0000_0000_0bad_cafe); set_rd(5, 0, 5);
    set_rd(6, 1, 16); set_wr(3, 1, 16, 64'h1111_2222_3333_4444); packet("R4");
    clear_pkt(); set_rd(0, 0, 5); set_rd(1, 1, 16); packet("R4");

    // R5: four disjoint writes commit together
    clear_pkt();
    set_wr(0, 0, 1, 64'h0000_0000_0000_0101); set_wr(1, 1, 2, 64'h0202_0202_0303_0303);
    set_wr(2, 0, 31, 64'h0000_0000_3131_3131); set_wr(3, 1, 28, 64'h2929_2929_2828_2828);
    packet("R5");
    sweep("R5");

    // R6 and R10: single overlaps upper half of a pair; reads still served
    clear_pkt(); set_wr(0, 0, 9, 64'h5555); set_wr(2, 1, 8, 64'h7777_7777_6666_6666);
    set_rd(7, 1, 2); packet("R10");
    clear_pkt(); set_rd(0, 1, 8); packet("R6");

    // R7 and R8: odd pair read, odd pair write dropped, neighbour commits
    clear_pkt(); set_rd(3, 1, 7); set_wr(3, 1, 9, 64'hffff_ffff_eeee_eeee);
    set_wr(0, 0, 9, 64'h0000_0000_0000_0909); packet("R8");
    clear_pkt(); set_rd(0, 1, 8); set_rd(1, 1, 11); packet("R7");

    // random packets in a narrow window to provoke overlaps
    for (int n = 0; n < 3000; n++) begin
      int win;
      clear_pkt();
      win = ($urandom % 4 == 0) ? 0 : int'($urandom % 24);
      for (int p = 0; p < NP; p++)
        if ($urandom % 4 != 0) set_rd(p, 1'($urandom), int'($urandom % NR));
      for (int s = 0; s < NS; s++)
        if ($urandom % 3 != 0)
          set_wr(s, 1'($urandom), win + int'($urandom % 8), {$urandom, $urandom});
      packet("");
    end
    sweep("R5");
    done = 1;
  end

  initial begin
    fork
      begin repeat (200000) @(posedge clk); end
      begin wait (done); end
    join_any
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule